// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Controller

A full-duplex serial port that frames characters with a start bit, data bits and one or two stop bits. Software talks to it through four word registers: a control word, a baud reload value, a data port and a status word. A write to the data port queues a character in a one-entry holding register. The transmit shifter takes it as soon as the shifter is free, so a second character can wait while the first is on the line. The receiver has its own one-entry buffer. It can collect a new frame while the previous character is still waiting to be read.

Bit timing comes from a reload counter that emits one oversample tick every `reload+1` clocks, with 16 ticks to a bit. The receiver waits for a low line and confirms the start bit at mid-bit. It then samples every later bit at mid-bit. The control word selects one of four frame formats: 8 data bits, 7 data bits plus a generated parity bit, 9 data bits, or 9 data bits with address filtering for multi-drop links. It also sets the parity sense, the stop-bit count and the receiver enable, and it can route the transmitter into the receiver for self-test.

Top module: `async_serial_ctrl`

## Requirements
- R1: After reset `txd` is high. Status reads 0x0003: bit0 (holding register empty) and bit1 (shifter idle) are set, and bit2 (receive full), bit3 (parity error), bit4 (framing error) and bit5 (overrun) are clear. Control (address 0) reads 0 and the data port (address 2) reads 0.
- R2: A frame is a low start bit, then the data bits LSB first, then one stop bit, or two when control bit3 is set. The mode is control bits[1:0]. Mode 0 sends 8 data bits, mode 1 sends 7 data bits plus parity, and modes 2 and 3 send 9 data bits.
- R3: In mode 1 the bit after the 7 data bits is the parity bit. It is the XOR of the seven bits when control bit2 is 0 (even sense) and the inverse of that XOR when bit2 is 1 (odd sense). A received parity bit is stored in data-port bit 7, and a mismatch sets status bit3.
- R4: A write to address 2 loads the holding register. When the shifter is idle, `txd` drops on the next clock edge. A character written while another is shifting follows it with no idle time, so consecutive start bits are exactly (frame bits)×16×(reload+1) clocks apart.
- R5: Address 1 holds the baud reload. One bit lasts 16×(reload+1) clocks, and the register reads back the value written.
- R6: A completed receive frame sets status bit2 and places the character in the data port. In 8-bit modes the character is zero-extended. A read of address 2 clears bit2.
- R7: While control bit4 (receive enable) is clear, no frame is received and status bit2 stays clear.
- R8: A frame that completes while status bit2 is set sets status bit5, and the data port then holds the newer character.
- R9: A low line at the stop-bit sample sets status bit4, and the character is still stored.
- R10: A start bit that is high again at its mid-bit sample is discarded: nothing is stored and no flag changes.
- R11: Status bits 3 to 5 stay set until status is read or any value is written to address 3.
- R12: With control bit5 set, the transmit shifter drives the receiver input, `txd` is held high and `rxd` is ignored.
- R13: In mode 3 a received frame whose ninth bit is 0 is dropped, and one whose ninth bit is 1 is stored. Mode 2 stores both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears on read take effect at the clock edge |
| reg_addr | input | 2 | 0 control, 1 baud reload, 2 data port, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` in the same cycle it raises the strobe. A clear caused by a read is expected from the following cycle on. After a data write, `txd` is expected low exactly one clock edge later. The spacing between transmitted start bits is measured in clocks and compared with frame bits × 16 × (reload+1). Each transmitted bit is sampled half a bit time after the observed falling edge.

On receive, the two-flop synchronizer and the mid-bit sampling place the completed character about 11 clocks into the stop bit when the reload is 0. The bench therefore reads status only after the whole stop bit has been driven, and it never polls status while an error flag is expected to survive, because a status read clears the flags.

// File: rtl/async_serial_ctrl.sv
module async_serial_ctrl #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rxd,
  output logic        txd
);
  localparam int SW = $clog2(OVS);
  localparam logic [SW-1:0] MID  = SW'(OVS / 2);
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_BAUD = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_baud = reg_wr && reg_addr == A_BAUD;
  wire wr_data = reg_wr && reg_addr == A_DATA;
  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire rd_data = reg_rd && reg_addr == A_DATA;
  wire rd_stat = reg_rd && reg_addr == A_STAT;

  logic [1:0] mode;
  logic odd, two_stop, rx_en, loop;
  logic [DIV_W-1:0] reload, bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 2'd0; odd <= 1'b0; two_stop <= 1'b0; rx_en <= 1'b0; loop <= 1'b0;
      reload <= '0;
    end else begin
      if (wr_ctrl) {loop, rx_en, two_stop, odd, mode} <= reg_wdata[5:0];
      if (wr_baud) reload <= reg_wdata[DIV_W-1:0];
    end
  end

  wire tick = (bcnt == '0);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? reload : bcnt - DIV_W'(1);
  end

  wire nine = mode[1];

  // transmit path
  logic [8:0]  thr;
  logic        thr_full, tx_busy;
  logic [11:0] tx_sh;
  logic [3:0]  tx_left;
  logic [SW-1:0] tx_sub;
  logic [8:0]  tx_word;
  wire  [3:0]  tx_nbits = 4'd10 + {3'b000, nine} + {3'b000, two_stop};
  wire         tx_par = (^thr[6:0]) ^ odd;

  always_comb begin
    case (mode)
      2'd0:    tx_word = {1'b1, thr[7:0]};
      2'd1:    tx_word = {1'b1, tx_par, thr[6:0]};
      default: tx_word = thr;
    endcase
  end

  wire tx_bit_end = tx_busy && tick && tx_sub == LAST;
  wire tx_done    = tx_bit_end && tx_left == 4'd1;
  wire tx_load    = thr_full && (!tx_busy || tx_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '1; tx_left <= 4'd0; tx_sub <= '0; tx_busy <= 1'b0;
      thr <= 9'd0; thr_full <= 1'b0;
    end else begin
      if (tx_load) begin
        tx_sh   <= {2'b11, tx_word, 1'b0};
        tx_left <= tx_nbits;
        tx_sub  <= '0;
        tx_busy <= 1'b1;
      end else if (tx_bit_end) begin
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_left <= tx_left - 4'd1;
        tx_sub  <= '0;
        if (tx_done) tx_busy <= 1'b0;
      end else if (tx_busy && tick) begin
        tx_sub <= tx_sub + SW'(1);
      end
      if (wr_data) begin
        thr <= reg_wdata[8:0];
        thr_full <= 1'b1;
      end else if (tx_load) begin
        thr_full <= 1'b0;
      end
    end
  end

  assign txd = loop ? 1'b1 : tx_sh[0];

  // receive path
  logic rx_m, rx_s;
  wire  rx_src = loop ? tx_sh[0] : rxd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rx_s, rx_m} <= 2'b11;
    else        {rx_s, rx_m} <= {rx_m, rx_src};
  end

  logic rx_busy;
  logic [SW-1:0] rx_sub;
  logic [3:0] rx_idx;
  logic [8:0] rx_sh;
  wire  [3:0] rx_last = nine ? 4'd10 : 4'd9;
  wire  rx_samp = rx_busy && tick && rx_sub == MID;
  wire  rx_stop = rx_samp && rx_idx == rx_last;
  wire  [8:0] rx_word = nine ? rx_sh : {1'b0, rx_sh[8:1]};
  wire  rx_commit = rx_stop && !(mode == 2'd3 && !rx_sh[8]);
  wire  rx_par_bad = (mode == 2'd1) && (rx_sh[8] != ((^rx_sh[7:1]) ^ odd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_sub <= '0; rx_idx <= 4'd0; rx_sh <= 9'd0;
    end else if (!rx_en) begin
      rx_busy <= 1'b0;
    end else if (!rx_busy) begin
      if (tick && !rx_s) begin
        rx_busy <= 1'b1; rx_sub <= SW'(1); rx_idx <= 4'd0; rx_sh <= 9'd0;
      end
    end else if (tick) begin
      rx_sub <= rx_sub + SW'(1);
      if (rx_sub == MID) begin
        rx_idx <= rx_idx + 4'd1;
        if ((rx_idx == 4'd0 && rx_s) || rx_idx == rx_last) rx_busy <= 1'b0;
        else if (rx_idx != 4'd0) rx_sh <= {rx_s, rx_sh[8:1]};
      end
    end
  end

  // receive buffer and flags
  logic [8:0] rbr;
  logic rx_full, perr, ferr, ovr;
  wire clr = rd_stat || wr_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr <= 9'd0; rx_full <= 1'b0; perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0;
    end else begin
      if (rx_commit) begin
        rbr <= rx_word;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
      perr <= (rx_commit && rx_par_bad) || (perr && !clr);
      ferr <= (rx_commit && !rx_s)      || (ferr && !clr);
      ovr  <= (rx_commit && rx_full && !rd_data) || (ovr && !clr);
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {10'd0, loop, rx_en, two_stop, odd, mode};
      A_BAUD:  reg_rdata = 16'(reload);
      A_DATA:  reg_rdata = {7'd0, rbr};
      default: reg_rdata = {10'd0, ovr, ferr, perr, rx_full, !tx_busy, !thr_full};
    endcase
  end

  a_r2_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_sh[0]);
  a_r4_start_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_sh[0]);
  a_r4_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> thr_full);
  a_r7_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_busy);
  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rx_commit && rx_full && !rd_data |=> ovr && rx_full);
  a_r9_framing: assert property (@(posedge clk) disable iff (!rst_n)
    rx_commit && !rx_s |=> ferr);
  a_r10_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    rx_samp && rx_idx == 4'd0 && rx_s |=> !rx_busy);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !clr |=> ovr);
endmodule

// File: tb/tb_async_serial_ctrl.sv
module tb_async_serial_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_BAUD = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;
  localparam logic [15:0] S_IDLE = 16'h0003, S_FULL = 16'h0007;
  // {mode[20:19], odd[18], written[17:9], expected[8:0]}
  localparam logic [20:0] VEC [9] = '{
    {2'd0, 1'b0, 9'h0A5, 9'h0A5},
    {2'd0, 1'b0, 9'h1FF, 9'h0FF},
    {2'd1, 1'b0, 9'h001, 9'h081},
    {2'd1, 1'b1, 9'h001, 9'h001},
    {2'd1, 1'b0, 9'h083, 9'h003},
    {2'd1, 1'b1, 9'h000, 9'h080},
    {2'd2, 1'b0, 9'h155, 9'h155},
    {2'd2, 1'b1, 9'h0AA, 9'h0AA},
    {2'd3, 1'b0, 9'h1C3, 9'h1C3}
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, rxd = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  wire [15:0] reg_rdata;
  wire txd;
  int n_chk = 0, n_bad = 0, cyc = 0;

  async_serial_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [15:0] cfg(input logic [1:0] m, input logic o, input logic two,
                                       input logic en, input logic lb);
    return {10'd0, lb, en, two, o, m};
  endfunction

  function automatic logic [11:0] fr8(input logic [7:0] d, input logic stop);
    return {2'b11, stop, d, 1'b0};
  endfunction

  function automatic logic [11:0] fr9(input logic [8:0] d);
    return {2'b11, d, 1'b0};
  endfunction

  task automatic send(input logic [11:0] bits, input int n, input int per);
    for (int i = 0; i < n; i++) begin
      rxd = bits[i];
      repeat (per) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic grab(input int n, input int per, output logic [11:0] bits, output int t0);
    int w = 0;
    bits = '1;
    while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    t0 = cyc;
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      if (i < n - 1) repeat (per) @(negedge clk);
    end
  endtask

  task automatic pair(input int n, input int per, input logic [8:0] a, input logic [8:0] b,
                      output logic [11:0] ba, output logic [11:0] bb, output int dt, output int lat);
    int c0, t1, t2;
    wr(A_DATA, {7'd0, a});
    c0 = cyc;
    fork
      begin grab(n, per, ba, t1); grab(n, per, bb, t2); end
      wr(A_DATA, {7'd0, b});
    join
    dt = t2 - t1;
    lat = t1 - c0;
    repeat (per) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [11:0] ba, bb;
    int dt, lat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 txd idle", {15'd0, txd}, 16'h0001);
    rd(A_STAT, v); chk("R1 status", v, S_IDLE);
    rd(A_CTRL, v); chk("R1 control", v, 16'h0000);
    rd(A_DATA, v); chk("R1 data", v, 16'h0000);

    // transmit framing and back-to-back
    wr(A_CTRL, cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    pair(10, 16, 9'h03C, 9'h0C3, ba, bb, dt, lat);
    chk("R2 frame 8 bit", {4'd0, ba}, {4'd0, fr8(8'h3C, 1'b1)});
    chk("R4 second frame", {4'd0, bb}, {4'd0, fr8(8'hC3, 1'b1)});
    chk("R4 no gap", 16'(dt), 16'd160);
    chk("R4 start latency", 16'(lat), 16'd1);

    wr(A_CTRL, cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    pair(11, 16, 9'h081, 9'h07E, ba, bb, dt, lat);
    chk("R2 two stop frame", {4'd0, ba}, {4'd0, fr8(8'h81, 1'b1)});
    chk("R2 two stop spacing", 16'(dt), 16'd176);

    wr(A_CTRL, cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b0));
    pair(10, 16, 9'h005, 9'h007, ba, bb, dt, lat);
    chk("R3 odd parity set", {4'd0, ba}, {4'd0, fr8({1'b1, 7'h05}, 1'b1)});
    chk("R3 odd parity clear", {4'd0, bb}, {4'd0, fr8({1'b0, 7'h07}, 1'b1)});

    wr(A_CTRL, cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0));
    pair(11, 16, 9'h1A5, 9'h05A, ba, bb, dt, lat);
    chk("R2 nine bit frame", {4'd0, ba}, {4'd0, fr9(9'h1A5)});
    chk("R2 nine bit spacing", 16'(dt), 16'd176);

    wr(A_BAUD, 16'd1);
    rd(A_BAUD, v); chk("R5 reload readback", v, 16'd1);
    wr(A_CTRL, cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    pair(10, 32, 9'h069, 9'h096, ba, bb, dt, lat);
    chk("R5 slow frame", {4'd0, ba}, {4'd0, fr8(8'h69, 1'b1)});
    chk("R5 slow spacing", 16'(dt), 16'd320);
    wr(A_BAUD, 16'd0);
    repeat (20) @(negedge clk);

    // loop-back vector table, external line held low to show it is ignored
    rxd = 1'b0;
    for (int k = 0; k < 9; k++) begin
      logic [20:0] e;
      e = VEC[k];
      wr(A_CTRL, cfg(e[20:19], e[18], 1'b0, 1'b1, 1'b1));
      wr(A_DATA, {7'd0, e[17:9]});
      repeat (40) @(negedge clk);
      chk("R12 txd held high", {15'd0, txd}, 16'h0001);
      repeat (200) @(negedge clk);
      rd(A_STAT, v); chk("R12 loop status", v, S_FULL);
      rd(A_DATA, v); chk("R12 R3 loop character", v, {7'd0, e[8:0]});
      rd(A_STAT, v); chk("R6 read clears full", v, S_IDLE);
    end
    rxd = 1'b1;
    wr(A_CTRL, cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (10) @(negedge clk);

    // external receive
    wr(A_CTRL, cfg(2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    send(fr8(8'h3C, 1'b1), 10, 16);
    rd(A_STAT, v); chk("R6 full after frame", v, S_FULL);
    rd(A_DATA, v); chk("R6 character", v, 16'h003C);

    send(fr8(8'h11, 1'b1), 10, 16);
    send(fr8(8'h22, 1'b1), 10, 16);
    rd(A_STAT, v); chk("R8 overrun flag", v, S_FULL | 16'h0020);
    rd(A_STAT, v); chk("R11 cleared by read", v, S_FULL);
    rd(A_DATA, v); chk("R8 newest kept", v, 16'h0022);

    send(fr8(8'h5A, 1'b0), 10, 16);
    rd(A_STAT, v); chk("R9 framing flag", v, S_FULL | 16'h0010);
    repeat (100) @(negedge clk);
    rd(A_STAT, v); chk("R10 false start ignored", v, S_FULL);
    rd(A_DATA, v); chk("R9 character stored", v, 16'h005A);

    wr(A_CTRL, cfg(2'd1, 1'b0, 1'b0, 1'b1, 1'b0));
    send(fr8({1'b0, 7'h01}, 1'b1), 10, 16);
    rd(A_DATA, v); chk("R3 bad parity char", v, 16'h0001);
    repeat (20) @(negedge clk);
    wr(A_STAT, 16'd0);
    rd(A_STAT, v); chk("R11 cleared by write", v, S_IDLE);
    send(fr8({1'b0, 7'h01}, 1'b1), 10, 16);
    rd(A_STAT, v); chk("R3 parity flag", v, S_FULL | 16'h0008);
    rd(A_DATA, v);
    send(fr8({1'b1, 7'h01}, 1'b1), 10, 16);
    rd(A_STAT, v); chk("R3 good parity", v, S_FULL);
    rd(A_DATA, v); chk("R3 parity in bit 7", v, 16'h0081);

    wr(A_CTRL, cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    send(fr8(8'h77, 1'b1), 10, 16);
    rd(A_STAT, v); chk("R7 disabled receiver", v, S_IDLE);

    wr(A_CTRL, cfg(2'd3, 1'b0, 1'b0, 1'b1, 1'b0));
    send(fr9(9'h0AB), 11, 16);
    rd(A_STAT, v); chk("R13 data frame dropped", v, S_IDLE);
    send(fr9(9'h1AB), 11, 16);
    rd(A_STAT, v); chk("R13 address accepted", v, S_FULL);
    rd(A_DATA, v); chk("R13 address value", v, 16'h01AB);
    wr(A_CTRL, cfg(2'd2, 1'b0, 1'b0, 1'b1, 1'b0));
    send(fr9(9'h0AB), 11, 16);
    rd(A_DATA, v); chk("R13 plain nine bit", v, 16'h00AB);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule